// File: doc/BRIEF.md
# Large-Core Acceleration Coordinator

This block decides what runs on each large core of an asymmetric multicore. Two kinds of work compete for those cores. Lagging threads are handed out at every scheduling quantum from a ranked list, with entry k going to large core k. Bottleneck requests arrive one at a time, each aimed at one large core and carrying a utility value.

A bottleneck runs only if its utility is strictly above a software-written threshold. A qualifying bottleneck that finds its core idle or running a lagging thread takes the core at once. If it preempts a lagging thread, a preempt command is pulsed. A qualifying bottleneck that finds its core already busy with a bottleneck waits in that core's first-in first-out buffer. When a bottleneck finishes, the oldest buffered one starts. When nothing is left running or buffered, the saved lagging thread is put back and a resume command is pulsed.

Each request gets a response one cycle later. The block reports, for each core, the running segment ID and a three-valued state. Moving contexts between cores and computing utilities are done elsewhere.

Top module: `accel_coord`

## Requirements
- R1: After reset every core is IDLE with running ID 0. No preempt or resume command is raised, no response is valid, and the threshold holds THR_RESET.
- R2: On a quantum pulse, every core not running a bottleneck takes list entry k (`lag_id` bits [k*ID_W +: ID_W], valid bit `lag_valid[k]`) in the following cycle. A valid entry gives LAGGING with that ID. An invalid entry gives IDLE with ID 0.
- R3: Every request gets `resp_valid` in the next cycle, with `resp_code` 0 = rejected (utility at or below threshold), 1 = running now, 2 = queued, 3 = rejected because the buffer is full. A rejected low-utility request changes no core state. A threshold write takes effect from the next cycle.
- R4: A qualifying request to a LAGGING core makes it BOTTLENECK with the request ID in the next cycle and pulses `preempt_cmd[k]` for exactly one cycle. To an IDLE core it does the same without a preempt pulse.
- R5: A qualifying request to a BOTTLENECK core whose buffer has room is queued (code 2). The running ID is unchanged.
- R6: A qualifying request to a BOTTLENECK core whose buffer holds BUF_DEPTH entries gets code 3 and is never run.
- R7: A return on a BOTTLENECK core with a non-empty buffer starts the oldest buffered ID in the next cycle. The core stays in BOTTLENECK.
- R8: A return on a BOTTLENECK core with an empty buffer restores the saved lagging thread in the next cycle (LAGGING, with a one-cycle `resume_cmd[k]`). If no thread is saved, the core goes IDLE with ID 0 and no resume.
- R9: A quantum pulse while a core runs a bottleneck leaves that bottleneck running. The new list entry replaces the saved lagging thread that R8 restores.
- R10: A return on a core that is not in BOTTLENECK has no effect.
- R11: The state of core k is at `core_state` bits [2k+1:2k] with IDLE = 0, LAGGING = 1, BOTTLENECK = 2; value 3 never appears. Its running ID is at `run_id` bits [k*ID_W +: ID_W].
- R12: A return with an empty buffer, arriving in the same cycle as a qualifying request to that core, starts the request directly (code 1). There is no resume pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quantum_tick | input | 1 | Quantum boundary pulse |
| lag_valid | input | NUM_CORES | Valid bit per ranked lagging-thread entry |
| lag_id | input | NUM_CORES*ID_W | Ranked lagging-thread IDs, entry k for core k |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | UTIL_W | New threshold value |
| bn_req_valid | input | 1 | Bottleneck request strobe |
| bn_req_core | input | CORE_W | Target large core |
| bn_req_id | input | ID_W | Bottleneck segment ID |
| bn_req_util | input | UTIL_W | Bottleneck utility |
| bn_ret | input | NUM_CORES | Bottleneck finished, per core |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_code | output | 2 | Response code |
| run_id | output | NUM_CORES*ID_W | Running segment ID per core |
| core_state | output | 2*NUM_CORES | State per core |
| preempt_cmd | output | NUM_CORES | Lagging thread displaced, per core |
| resume_cmd | output | NUM_CORES | Lagging thread restored, per core |

## Verification
The bench builds the block with two large cores, a buffer depth of 3 and a reset threshold of 100. The depth of 3 makes the buffer-full rejection reachable after three queued requests. Because 3 is not a power of two, the buffer pointers must wrap explicitly rather than roll over. With two cores, routing by target core can be checked: the bench confirms that a quantum changes an idle core while a busy one keeps its bottleneck, and that a return on the idle core does nothing.

// File: rtl/accel_coord_pkg.sv
// Package: shared encodings for the large-core acceleration coordinator.
// Assumes: state and response codes are visible on ports, so values are fixed.
package accel_coord_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAGGING = 2'd1,
        ST_BOTTLE  = 2'd2
    } core_state_e;

    typedef enum logic [1:0] {
        RESP_REJ_LOW  = 2'd0,
        RESP_RUN      = 2'd1,
        RESP_QUEUED   = 2'd2,
        RESP_REJ_FULL = 2'd3
    } resp_code_e;

endpackage

// File: rtl/accel_thr_gate.sv
// Module: accel_thr_gate
// Holds the bottleneck utility threshold and qualifies incoming utilities.
// Assumes: a qualifying utility is strictly greater than the stored value;
// a write is visible from the cycle after the strobe.
module accel_thr_gate #(
    parameter int UTIL_W    = 8,
    parameter int THR_RESET = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [UTIL_W-1:0] wr_data,
    input  logic [UTIL_W-1:0] util_in,
    output logic [UTIL_W-1:0] thr_value,
    output logic              qualifies
);

    logic [UTIL_W-1:0] thr_r;

    // Purpose: keep the software-written threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_r <= UTIL_W'(THR_RESET);
        end else if (wr_en) begin
            thr_r <= wr_data;
        end
    end

    // Purpose: strict comparison against the stored threshold.
    always_comb begin
        qualifies = (util_in > thr_r);
    end

    assign thr_value = thr_r;

endmodule

// File: rtl/accel_sched_fifo.sv
// Module: accel_sched_fifo
// First-in first-out buffer of waiting bottleneck IDs for one large core.
// Assumes: the caller never pushes when full unless it also pops in the same
// cycle; the head is valid whenever empty is low. Depth need not be a power of two.
module accel_sched_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Purpose: advance pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Purpose: store the pushed ID; storage needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Purpose: expose the oldest entry and the fill flags.
    always_comb begin
        head  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end

endmodule

// File: rtl/accel_core_ctrl.sv
// Module: accel_core_ctrl
// Arbitration for one large core. It switches between the quantum's lagging
// thread and threshold-qualified bottlenecks, and owns the core's buffer.
// Assumes: req_hit is one cycle wide per request; req_qual comes from the
// shared threshold gate; a return is only meaningful in the BOTTLENECK state.
module accel_core_ctrl
    import accel_coord_pkg::*;
#(
    parameter int ID_W      = 6,
    parameter int BUF_DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            qtick,
    input  logic            lag_valid_i,
    input  logic [ID_W-1:0] lag_id_i,
    input  logic            req_hit,
    input  logic            req_qual,
    input  logic [ID_W-1:0] req_id,
    input  logic            ret_i,
    output core_state_e     state_o,
    output logic [ID_W-1:0] run_id_o,
    output logic            preempt_o,
    output logic            resume_o,
    output resp_code_e      code_o
);

    core_state_e     state_r;
    logic [ID_W-1:0] run_r;
    logic            saved_valid_r;
    logic [ID_W-1:0] saved_id_r;
    logic            preempt_r;
    logic            resume_r;

    logic            is_bn;
    logic            accepted;
    logic            pop;
    logic            finish_empty;
    logic            direct;
    logic            push;
    logic            fifo_empty;
    logic            fifo_full;
    logic [ID_W-1:0] fifo_head;
    logic            next_saved_valid;
    logic [ID_W-1:0] next_saved_id;

    // Purpose: decode this cycle's events into buffer and dispatch actions.
    always_comb begin
        is_bn        = (state_r == ST_BOTTLE);
        accepted     = req_hit && req_qual;
        pop          = is_bn && ret_i && !fifo_empty;
        finish_empty = is_bn && ret_i && fifo_empty;
        direct       = accepted && (!is_bn || finish_empty);
        push         = accepted && is_bn && !finish_empty && (!fifo_full || pop);
        next_saved_valid = qtick ? lag_valid_i : saved_valid_r;
        next_saved_id    = qtick ? lag_id_i    : saved_id_r;
    end

    // Purpose: classify the request for the response channel.
    always_comb begin
        if (!req_qual) begin
            code_o = RESP_REJ_LOW;
        end else if (direct) begin
            code_o = RESP_RUN;
        end else if (push) begin
            code_o = RESP_QUEUED;
        end else begin
            code_o = RESP_REJ_FULL;
        end
    end

    // Purpose: remember the latest quantum assignment for later restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_valid_r <= 1'b0;
            saved_id_r    <= '0;
        end else if (qtick) begin
            saved_valid_r <= lag_valid_i;
            saved_id_r    <= lag_valid_i ? lag_id_i : '0;
        end
    end

    // Purpose: core state, running ID and one-cycle command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r   <= ST_IDLE;
            run_r     <= '0;
            preempt_r <= 1'b0;
            resume_r  <= 1'b0;
        end else begin
            preempt_r <= 1'b0;
            resume_r  <= 1'b0;
            if (direct) begin
                state_r   <= ST_BOTTLE;
                run_r     <= req_id;
                preempt_r <= (state_r == ST_LAGGING);
            end else if (pop) begin
                run_r <= fifo_head;
            end else if (finish_empty) begin
                state_r  <= next_saved_valid ? ST_LAGGING : ST_IDLE;
                run_r    <= next_saved_valid ? next_saved_id : '0;
                resume_r <= next_saved_valid;
            end else if (qtick && !is_bn) begin
                state_r <= lag_valid_i ? ST_LAGGING : ST_IDLE;
                run_r   <= lag_valid_i ? lag_id_i : '0;
            end
        end
    end

    accel_sched_fifo #(
        .DEPTH (BUF_DEPTH),
        .W     (ID_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (req_id),
        .head  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign state_o   = state_r;
    assign run_id_o  = run_r;
    assign preempt_o = preempt_r;
    assign resume_o  = resume_r;

endmodule

// File: rtl/accel_coord.sv
// Module: accel_coord (top)
// Large-core acceleration coordinator: per-quantum lagging-thread grants,
// threshold-gated bottleneck preemption, and per-core waiting buffers.
// Assumes: at most one bottleneck request per cycle; lag entry k belongs to core k.
module accel_coord
    import accel_coord_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ID_W      = 6,
    parameter int UTIL_W    = 8,
    parameter int BUF_DEPTH = 4,
    parameter int THR_RESET = 100,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      quantum_tick,
    input  logic [NUM_CORES-1:0]      lag_valid,
    input  logic [NUM_CORES*ID_W-1:0] lag_id,
    input  logic                      thr_we,
    input  logic [UTIL_W-1:0]         thr_wdata,
    input  logic                      bn_req_valid,
    input  logic [CORE_W-1:0]         bn_req_core,
    input  logic [ID_W-1:0]           bn_req_id,
    input  logic [UTIL_W-1:0]         bn_req_util,
    input  logic [NUM_CORES-1:0]      bn_ret,
    output logic                      resp_valid,
    output logic [1:0]                resp_code,
    output logic [NUM_CORES*ID_W-1:0] run_id,
    output logic [2*NUM_CORES-1:0]    core_state,
    output logic [NUM_CORES-1:0]      preempt_cmd,
    output logic [NUM_CORES-1:0]      resume_cmd
);

    logic [UTIL_W-1:0]    thr_q;
    logic                 req_qual;
    logic [NUM_CORES-1:0] req_hit;
    resp_code_e           core_code [NUM_CORES];
    resp_code_e           code_sel;
    logic                 resp_valid_r;
    resp_code_e           resp_code_r;

    accel_thr_gate #(
        .UTIL_W    (UTIL_W),
        .THR_RESET (THR_RESET)
    ) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (thr_we),
        .wr_data   (thr_wdata),
        .util_in   (bn_req_util),
        .thr_value (thr_q),
        .qualifies (req_qual)
    );

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        core_state_e st;

        // Purpose: route the request to its target core.
        always_comb begin
            req_hit[k] = bn_req_valid && (bn_req_core == CORE_W'(k));
        end

        accel_core_ctrl #(
            .ID_W      (ID_W),
            .BUF_DEPTH (BUF_DEPTH)
        ) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .qtick       (quantum_tick),
            .lag_valid_i (lag_valid[k]),
            .lag_id_i    (lag_id[k*ID_W +: ID_W]),
            .req_hit     (req_hit[k]),
            .req_qual    (req_qual),
            .req_id      (bn_req_id),
            .ret_i       (bn_ret[k]),
            .state_o     (st),
            .run_id_o    (run_id[k*ID_W +: ID_W]),
            .preempt_o   (preempt_cmd[k]),
            .resume_o    (resume_cmd[k]),
            .code_o      (core_code[k])
        );

        assign core_state[2*k +: 2] = st;
    end

    // Purpose: pick the response of the addressed core.
    always_comb begin
        code_sel = RESP_REJ_LOW;
        for (int k = 0; k < NUM_CORES; k++) begin
            if (req_hit[k]) begin
                code_sel = core_code[k];
            end
        end
    end

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_r <= 1'b0;
            resp_code_r  <= RESP_REJ_LOW;
        end else begin
            resp_valid_r <= bn_req_valid;
            resp_code_r  <= bn_req_valid ? code_sel : RESP_REJ_LOW;
        end
    end

    assign resp_valid = resp_valid_r;
    assign resp_code  = resp_code_r;

endmodule

// File: rtl/accel_coord_chk.sv
// Module: accel_coord_chk
// Temporal checks on the coordinator's ports and threshold register.
// Assumes: attached to every accel_coord instance through the bind below.
module accel_coord_chk #(
    parameter int NUM_CORES = 2,
    parameter int ID_W      = 6,
    parameter int UTIL_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bn_req_valid,
    input logic [UTIL_W-1:0]         bn_req_util,
    input logic [UTIL_W-1:0]         thr_q,
    input logic [NUM_CORES-1:0]      bn_ret,
    input logic                      resp_valid,
    input logic [1:0]                resp_code,
    input logic [NUM_CORES*ID_W-1:0] run_id,
    input logic [2*NUM_CORES-1:0]    core_state,
    input logic [NUM_CORES-1:0]      preempt_cmd,
    input logic [NUM_CORES-1:0]      resume_cmd
);

    assert_low_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bn_req_valid && bn_req_util <= thr_q) |=> (resp_valid && resp_code == 2'd0));

    assert_resp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(bn_req_valid));

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_chk
        assert_preempt_from_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            preempt_cmd[k] |-> (core_state[2*k +: 2] == 2'd2 && $past(core_state[2*k +: 2]) == 2'd1));

        assert_resume_to_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            resume_cmd[k] |-> (core_state[2*k +: 2] == 2'd1 && $past(core_state[2*k +: 2]) == 2'd2));

        assert_bn_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (core_state[2*k +: 2] == 2'd2 && $past(core_state[2*k +: 2]) == 2'd2 && !$past(bn_ret[k]))
            |-> $stable(run_id[k*ID_W +: ID_W]));

        assert_legal_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
            core_state[2*k +: 2] != 2'd3);

        assert_idle_zero_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (core_state[2*k +: 2] == 2'd0) |-> (run_id[k*ID_W +: ID_W] == '0));

        assert_no_dual_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !(preempt_cmd[k] && resume_cmd[k]));
    end

endmodule

bind accel_coord accel_coord_chk #(
    .NUM_CORES (NUM_CORES),
    .ID_W      (ID_W),
    .UTIL_W    (UTIL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bn_req_valid (bn_req_valid),
    .bn_req_util  (bn_req_util),
    .thr_q        (thr_q),
    .bn_ret       (bn_ret),
    .resp_valid   (resp_valid),
    .resp_code    (resp_code),
    .run_id       (run_id),
    .core_state   (core_state),
    .preempt_cmd  (preempt_cmd),
    .resume_cmd   (resume_cmd)
);

// File: tb/accel_coord_bench.sv
// Scoreboard bench: the driver queues expected response codes, and a monitor
// pops and compares them as responses appear. State and command outputs are
// checked directly at the falling edge.
module accel_coord_bench;

    localparam int NC  = 2;
    localparam int IW  = 6;
    localparam int UW  = 8;
    localparam int DEP = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            quantum_tick = 1'b0;
    logic [NC-1:0]   lag_valid = '0;
    logic [NC*IW-1:0] lag_id = '0;
    logic            thr_we = 1'b0;
    logic [UW-1:0]   thr_wdata = '0;
    logic            bn_req_valid = 1'b0;
    logic [0:0]      bn_req_core = '0;
    logic [IW-1:0]   bn_req_id = '0;
    logic [UW-1:0]   bn_req_util = '0;
    logic [NC-1:0]   bn_ret = '0;
    logic            resp_valid;
    logic [1:0]      resp_code;
    logic [NC*IW-1:0] run_id;
    logic [2*NC-1:0] core_state;
    logic [NC-1:0]   preempt_cmd;
    logic [NC-1:0]   resume_cmd;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    accel_coord #(
        .NUM_CORES (NC), .ID_W (IW), .UTIL_W (UW),
        .BUF_DEPTH (DEP), .THR_RESET (100)
    ) u_accel_coord (
        .clk (clk), .rst_n (rst_n), .quantum_tick (quantum_tick),
        .lag_valid (lag_valid), .lag_id (lag_id), .thr_we (thr_we),
        .thr_wdata (thr_wdata), .bn_req_valid (bn_req_valid),
        .bn_req_core (bn_req_core), .bn_req_id (bn_req_id),
        .bn_req_util (bn_req_util), .bn_ret (bn_ret),
        .resp_valid (resp_valid), .resp_code (resp_code), .run_id (run_id),
        .core_state (core_state), .preempt_cmd (preempt_cmd),
        .resume_cmd (resume_cmd)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_core(input string tag, input int k, input int st,
                              input int id, input int pre, input int res);
        check({tag, " state"},   int'(core_state[2*k +: 2]), st);
        check({tag, " run_id"},  int'(run_id[k*IW +: IW]), id);
        check({tag, " preempt"}, int'(preempt_cmd[k]), pre);
        check({tag, " resume"},  int'(resume_cmd[k]), res);
    endtask

    // Wait one falling edge, then drop all one-cycle strobes.
    task automatic step();
        @(negedge clk);
        quantum_tick = 1'b0;
        thr_we       = 1'b0;
        bn_req_valid = 1'b0;
        bn_ret       = '0;
    endtask

    // Driver: present a request and queue the expected response code.
    task automatic request(input int core, input int id, input int util,
                           input int exp_code, input string tag);
        bn_req_valid = 1'b1;
        bn_req_core  = 1'(core);
        bn_req_id    = IW'(id);
        bn_req_util  = UW'(util);
        exp_q.push_back(exp_code);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each response against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected response", int'(resp_code), -1);
            end else begin
                check(tag_q.pop_front(), int'(resp_code), exp_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1: reset state
        check_core("R1 core0", 0, 0, 0, 0, 0);
        check_core("R1 core1", 1, 0, 0, 0, 0);
        check("R1 resp_valid", int'(resp_valid), 0);
        // R1: reset threshold is 100, so utility 100 is rejected
        request(0, 1, 100, 0, "R1 threshold reset reject");
        step();
        step();
        check_core("R3 reject leaves idle", 0, 0, 0, 0, 0);

        // R2 / R11: quantum assigns entry k to core k
        quantum_tick = 1'b1; lag_valid = 2'b11;
        lag_id = {IW'(9), IW'(5)};
        step();
        check_core("R2 core0 lag", 0, 1, 5, 0, 0);
        check_core("R11 core1 lag", 1, 1, 9, 0, 0);

        // R3: threshold write, at-threshold request rejected
        thr_we = 1'b1; thr_wdata = 8'd50;
        step();
        request(0, 20, 50, 0, "R3 at threshold");
        step();
        check_core("R3 no state change", 0, 1, 5, 0, 0);

        // R4: preempt lagging thread on core0
        request(0, 20, 51, 1, "R4 preempt run");
        step();
        check_core("R4 core0 preempted", 0, 2, 20, 1, 0);
        check_core("R4 core1 untouched", 1, 1, 9, 0, 0);

        // R5: queue three, R6: fourth is rejected
        request(0, 21, 200, 2, "R5 queue 21");
        step();
        check_core("R4 pulse one cycle", 0, 2, 20, 0, 0);
        request(0, 22, 90, 2, "R5 queue 22");
        step();
        request(0, 23, 90, 2, "R5 queue 23");
        step();
        request(0, 24, 90, 3, "R6 full reject");
        step();
        check_core("R5 running unchanged", 0, 2, 20, 0, 0);

        // R9: quantum during bottleneck; core1 loses its entry
        quantum_tick = 1'b1; lag_valid = 2'b01;
        lag_id = {IW'(33), IW'(7)};
        step();
        check_core("R9 bottleneck kept", 0, 2, 20, 0, 0);
        check_core("R2 core1 idle", 1, 0, 0, 0, 0);

        // R10: return on an idle core is ignored
        bn_ret = 2'b10;
        step();
        check_core("R10 idle ignores return", 1, 0, 0, 0, 0);
        check_core("R10 core0 unaffected", 0, 2, 20, 0, 0);

        // R7: drain in arrival order
        bn_ret = 2'b01;
        step();
        check_core("R7 first buffered", 0, 2, 21, 0, 0);
        bn_ret = 2'b01;
        step();
        check_core("R7 second buffered", 0, 2, 22, 0, 0);
        bn_ret = 2'b01;
        step();
        check_core("R7 third buffered", 0, 2, 23, 0, 0);
        // R8 / R9 / R6: restore new saved thread; rejected 24 never runs
        bn_ret = 2'b01;
        step();
        check_core("R8 restore saved", 0, 1, 7, 0, 1);
        step();
        check_core("R8 resume one cycle", 0, 1, 7, 0, 0);

        // R4: request to idle core runs without preempt
        request(1, 30, 60, 1, "R4 idle run");
        step();
        check_core("R4 idle no preempt", 1, 2, 30, 0, 0);

        // R12: return and request together with empty buffer
        bn_ret = 2'b10;
        request(1, 31, 70, 1, "R12 direct run");
        step();
        check_core("R12 direct no resume", 1, 2, 31, 0, 0);

        // R8: return with nothing saved goes idle
        bn_ret = 2'b10;
        step();
        check_core("R8 idle no resume", 1, 0, 0, 0, 0);
        step();
        check("R3 all responses seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule